// File: doc/BRIEF.md
# Copy-Request Circuit Setup Sequencer

This block is the central controller of a circuit-switched inter-bank network inside a stacked memory. Requests to copy a block from one bank to another are queued here in arrival order. One request at a time is handed to an external slot allocator, which reports a start slot in the repeating time window and the number of hops along the path it found. The sequencer then programs the routers' slot tables, sends a read to the source vault controller so that data enters the circuit at the start slot, and sends a write to the destination vault controller at the cycle when the last beat reaches the destination.

Each 64-bit beat of the block occupies the reserved slot in one window, so a request of `len` beats keeps the circuit for `len` windows. A request with length zero is treated as one beat. Circuit latency is fixed, so every event is derived from a single counter that starts in the cycle the path is found. When the reservation ends, a release record is sent so that the allocator can free the slots. The block then takes the next queued request. Commands to the vault controllers carry a flag that steers them into the high-priority copy queue.

Top module: `copy_setup_seq`

## Requirements
- R1: After reset `cur_slot` is 0, `busy` is low, the queue is empty (`q_empty` high, `req_ready` high), and no request, program, vault, done or release pulse is raised.
- R2: `cur_slot` advances by one every cycle, modulo the window size N = 2^SLOT_W. `alloc_min_slot` equals `cur_slot` + 3 modulo N.
- R3: A request is accepted in any cycle where `req_valid` and `req_ready` are both high. `req_ready` is low exactly when DEPTH requests are held (`q_full`). Requests are presented to the allocator strictly in arrival order.
- R4: `alloc_req` is high exactly when the sequencer is idle and the queue is non-empty. `busy` is high from the cycle after a successful allocation through the release cycle, inclusive.
- R5: If `alloc_ok` is low while `alloc_req` is high, the head request stays queued and is offered again in the next cycle.
- R6: Exactly one cycle after a successful allocation, `prog_valid` pulses for one cycle and carries source, destination, start slot, hop count and request ID.
- R7: Call the allocation cycle t. The start cycle S is the first cycle at or after t+3 in which `cur_slot` equals the allocated start slot. The source read (`vc_valid`=1, `vc_write`=0, `vc_bank`=source) is issued in cycle S-1.
- R8: The destination write (`vc_valid`=1, `vc_write`=1, `vc_bank`=destination) and `done_valid` with `done_id` are issued in cycle S + (W-1)·N + hops. Here W is the request length, or 1 if the length is 0. In that cycle `cur_slot` equals start+hops modulo N.
- R9: `vc_copy` is high on every vault command.
- R10: `rel_valid` pulses in cycle S + W·N with the reservation's source, destination, start slot and hops. `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Copy request offered |
| req_ready | output | 1 | Queue can accept a request |
| req_id | input | ID_W | Request tag |
| req_src | input | BANK_W | Source bank |
| req_dst | input | BANK_W | Destination bank |
| req_len | input | LEN_W | Block length in 64-bit beats (0 means 1) |
| q_full | output | 1 | Queue holds DEPTH requests |
| q_empty | output | 1 | Queue holds no request |
| busy | output | 1 | A circuit is in progress |
| cur_slot | output | SLOT_W | Current slot of the time window |
| alloc_req | output | 1 | Path search requested for the head request |
| alloc_src | output | BANK_W | Source bank for the search |
| alloc_dst | output | BANK_W | Destination bank for the search |
| alloc_min_slot | output | SLOT_W | Earliest usable start slot |
| alloc_ok | input | 1 | Allocator found a free circuit |
| alloc_slot | input | SLOT_W | Start slot at the source router |
| alloc_hops | input | SLOT_W | Hops from source to destination |
| prog_valid | output | 1 | Slot-table programming pulse |
| prog_src | output | BANK_W | Circuit source |
| prog_dst | output | BANK_W | Circuit destination |
| prog_slot | output | SLOT_W | Circuit start slot |
| prog_hops | output | SLOT_W | Circuit hop count |
| prog_id | output | ID_W | Request tag |
| vc_valid | output | 1 | Vault controller command |
| vc_write | output | 1 | 1 = destination write, 0 = source read |
| vc_bank | output | BANK_W | Target bank of the command |
| vc_copy | output | 1 | Copy-traffic flag |
| done_valid | output | 1 | Destination write issued |
| done_id | output | ID_W | Tag of the finished request |
| rel_valid | output | 1 | Reservation released |
| rel_src | output | BANK_W | Released circuit source |
| rel_dst | output | BANK_W | Released circuit destination |
| rel_slot | output | SLOT_W | Released start slot |
| rel_hops | output | SLOT_W | Released hop count |

## Verification
The bench tests a start slot at exactly three slots ahead, and start slots one slot or zero slots ahead. For the latter two, a design that skipped the wrap would fire the read before setup is complete or in the wrong window. It also covers a zero-length request, where a design that took the length literally would release before it wrote, and the largest hop count, where the write falls in the last slot before release. Refused allocations check that the head is neither dropped nor reordered. A burst longer than the queue checks that `req_ready` falls at exactly DEPTH entries and that tags come back in arrival order.

// File: rtl/copy_seq_pkg.sv
package copy_seq_pkg;

  // Cycles between the path search and the first usable slot.
  localparam int unsigned SETUP_CYCLES = 3;

  typedef enum logic {SEQ_IDLE, SEQ_ACTIVE} seq_state_t;

  // Cycles from the search cycle to the start cycle of the circuit.
  function automatic int unsigned lead_cycles(input int unsigned start,
                                              input int unsigned cur,
                                              input int unsigned nslot);
    int unsigned d;
    d = (start + nslot - cur) % nslot;
    if (d < SETUP_CYCLES) d = d + nslot;
    return d;
  endfunction

  function automatic int unsigned eff_windows(input int unsigned len);
    return (len == 0) ? 1 : len;
  endfunction

  // Offset of the cycle in which the last beat reaches the destination.
  function automatic int unsigned write_offset(input int unsigned lead,
                                               input int unsigned win,
                                               input int unsigned hops,
                                               input int unsigned nslot);
    return lead + (win - 1) * nslot + hops;
  endfunction

  // Offset of the cycle in which the reservation ends.
  function automatic int unsigned release_offset(input int unsigned lead,
                                                 input int unsigned win,
                                                 input int unsigned nslot);
    return lead + win * nslot;
  endfunction

endpackage

// File: rtl/copy_req_fifo.sv
module copy_req_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_p, wr_p;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_p] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_p <= '0;
      wr_p <= '0;
      cnt  <= '0;
    end else begin
      if (push) wr_p <= step(wr_p);
      if (pop)  rd_p <= step(rd_p);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign head  = mem[rd_p];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R3

endmodule

// File: rtl/slot_clock.sv
module slot_clock import copy_seq_pkg::*; #(
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] cur_slot,
  output logic [SLOT_W-1:0] min_slot
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_slot <= '0;
    else        cur_slot <= cur_slot + SLOT_W'(1);
  end

  assign min_slot = cur_slot + SLOT_W'(SETUP_CYCLES);

endmodule

// File: rtl/copy_timeline.sv
module copy_timeline import copy_seq_pkg::*; #(
  parameter int SLOT_W = 4,
  parameter int ID_W   = 4,
  parameter int BANK_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_valid,
  input  logic [ID_W-1:0]   head_id,
  input  logic [BANK_W-1:0] head_src,
  input  logic [BANK_W-1:0] head_dst,
  input  logic [LEN_W-1:0]  head_len,
  input  logic              alloc_ok,
  input  logic [SLOT_W-1:0] alloc_slot,
  input  logic [SLOT_W-1:0] alloc_hops,
  input  logic [SLOT_W-1:0] cur_slot,
  output logic              alloc_req,
  output logic              pop,
  output logic              busy,
  output logic              prog_pulse,
  output logic              rd_pulse,
  output logic              wr_pulse,
  output logic              rel_pulse,
  output logic [ID_W-1:0]   id_q,
  output logic [BANK_W-1:0] src_q,
  output logic [BANK_W-1:0] dst_q,
  output logic [SLOT_W-1:0] start_q,
  output logic [SLOT_W-1:0] hops_q
);
  localparam int NSLOT = 1 << SLOT_W;
  localparam int CNT_W = LEN_W + SLOT_W + 2;

  seq_state_t       st;
  logic [CNT_W-1:0] elapsed, lead_q, wr_at_q, rel_at_q;
  logic [CNT_W-1:0] lead_n, wr_at_n, rel_at_n;
  logic             active, found;
  int unsigned      win_n;

  always_comb begin
    win_n    = eff_windows(32'(head_len));
    lead_n   = CNT_W'(lead_cycles(32'(alloc_slot), 32'(cur_slot), NSLOT));
    wr_at_n  = CNT_W'(write_offset(32'(lead_n), win_n, 32'(alloc_hops), NSLOT));
    rel_at_n = CNT_W'(release_offset(32'(lead_n), win_n, NSLOT));
  end

  assign active    = (st == SEQ_ACTIVE);
  assign alloc_req = !active && head_valid;
  assign found     = alloc_req && alloc_ok;
  assign pop       = found;
  assign busy      = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SEQ_IDLE;
      elapsed  <= '0;
      lead_q   <= '0;
      wr_at_q  <= '0;
      rel_at_q <= '0;
      id_q     <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      start_q  <= '0;
      hops_q   <= '0;
    end else if (!active) begin
      if (found) begin
        st       <= SEQ_ACTIVE;
        elapsed  <= CNT_W'(1);
        lead_q   <= lead_n;
        wr_at_q  <= wr_at_n;
        rel_at_q <= rel_at_n;
        id_q     <= head_id;
        src_q    <= head_src;
        dst_q    <= head_dst;
        start_q  <= alloc_slot;
        hops_q   <= alloc_hops;
      end
    end else if (elapsed == rel_at_q) begin
      st      <= SEQ_IDLE;
      elapsed <= '0;
    end else begin
      elapsed <= elapsed + CNT_W'(1);
    end
  end

  assign prog_pulse = active && (elapsed == CNT_W'(1));
  assign rd_pulse   = active && (elapsed == lead_q - CNT_W'(1));
  assign wr_pulse   = active && (elapsed == wr_at_q);
  assign rel_pulse  = active && (elapsed == rel_at_q);

  AST_RETRY_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && !alloc_ok) |=> alloc_req); // R5
  AST_PROG_AFTER_FIND: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> prog_pulse); // R6
  AST_READ_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse |=> (cur_slot == start_q)); // R7
  AST_WRITE_ON_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> (cur_slot == SLOT_W'(start_q + hops_q))); // R8
  AST_RELEASE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse |=> !busy); // R10

endmodule

// File: rtl/copy_setup_seq.sv
module copy_setup_seq #(
  parameter int SLOT_W = 4,
  parameter int ID_W   = 4,
  parameter int BANK_W = 8,
  parameter int LEN_W  = 4,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_id,
  input  logic [BANK_W-1:0] req_src,
  input  logic [BANK_W-1:0] req_dst,
  input  logic [LEN_W-1:0]  req_len,
  output logic              q_full,
  output logic              q_empty,
  output logic              busy,
  output logic [SLOT_W-1:0] cur_slot,
  output logic              alloc_req,
  output logic [BANK_W-1:0] alloc_src,
  output logic [BANK_W-1:0] alloc_dst,
  output logic [SLOT_W-1:0] alloc_min_slot,
  input  logic              alloc_ok,
  input  logic [SLOT_W-1:0] alloc_slot,
  input  logic [SLOT_W-1:0] alloc_hops,
  output logic              prog_valid,
  output logic [BANK_W-1:0] prog_src,
  output logic [BANK_W-1:0] prog_dst,
  output logic [SLOT_W-1:0] prog_slot,
  output logic [SLOT_W-1:0] prog_hops,
  output logic [ID_W-1:0]   prog_id,
  output logic              vc_valid,
  output logic              vc_write,
  output logic [BANK_W-1:0] vc_bank,
  output logic              vc_copy,
  output logic              done_valid,
  output logic [ID_W-1:0]   done_id,
  output logic              rel_valid,
  output logic [BANK_W-1:0] rel_src,
  output logic [BANK_W-1:0] rel_dst,
  output logic [SLOT_W-1:0] rel_slot,
  output logic [SLOT_W-1:0] rel_hops
);
  localparam int RW = ID_W + 2 * BANK_W + LEN_W;

  logic [RW-1:0]     head;
  logic              push, pop;
  logic [ID_W-1:0]   head_id, id_q;
  logic [BANK_W-1:0] head_src, head_dst, src_q, dst_q;
  logic [LEN_W-1:0]  head_len;
  logic [SLOT_W-1:0] start_q, hops_q;
  logic              rd_pulse, wr_pulse;

  assign req_ready = !q_full;
  assign push      = req_valid && req_ready;
  assign {head_id, head_src, head_dst, head_len} = head;

  copy_req_fifo #(.W(RW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push),
    .din({req_id, req_src, req_dst, req_len}),
    .pop(pop), .head(head), .full(q_full), .empty(q_empty)
  );

  slot_clock #(.SLOT_W(SLOT_W)) u_clock (
    .clk(clk), .rst_n(rst_n), .cur_slot(cur_slot), .min_slot(alloc_min_slot)
  );

  copy_timeline #(.SLOT_W(SLOT_W), .ID_W(ID_W), .BANK_W(BANK_W), .LEN_W(LEN_W)) u_time (
    .clk(clk), .rst_n(rst_n), .head_valid(!q_empty),
    .head_id(head_id), .head_src(head_src), .head_dst(head_dst), .head_len(head_len),
    .alloc_ok(alloc_ok), .alloc_slot(alloc_slot), .alloc_hops(alloc_hops),
    .cur_slot(cur_slot), .alloc_req(alloc_req), .pop(pop), .busy(busy),
    .prog_pulse(prog_valid), .rd_pulse(rd_pulse), .wr_pulse(wr_pulse),
    .rel_pulse(rel_valid), .id_q(id_q), .src_q(src_q), .dst_q(dst_q),
    .start_q(start_q), .hops_q(hops_q)
  );

  assign alloc_src  = head_src;
  assign alloc_dst  = head_dst;
  assign prog_src   = src_q;
  assign prog_dst   = dst_q;
  assign prog_slot  = start_q;
  assign prog_hops  = hops_q;
  assign prog_id    = id_q;
  assign vc_valid   = rd_pulse || wr_pulse;
  assign vc_write   = wr_pulse;
  assign vc_bank    = wr_pulse ? dst_q : src_q;
  assign vc_copy    = vc_valid;
  assign done_valid = wr_pulse;
  assign done_id    = id_q;
  assign rel_src    = src_q;
  assign rel_dst    = dst_q;
  assign rel_slot   = start_q;
  assign rel_hops   = hops_q;

  AST_ONE_VAULT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_pulse && wr_pulse)); // R8
  AST_BUSY_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_valid || vc_valid || rel_valid) |-> busy); // R4

endmodule

// File: tb/copy_setup_seq_test.sv
module copy_setup_seq_test;
  localparam int SLOT_W = 4, ID_W = 4, BANK_W = 8, LEN_W = 4, DEPTH = 4;
  localparam int N = 1 << SLOT_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, alloc_ok = 0;
  logic [ID_W-1:0] req_id = 0;
  logic [BANK_W-1:0] req_src = 0, req_dst = 0;
  logic [LEN_W-1:0] req_len = 0;
  logic [SLOT_W-1:0] alloc_slot = 0, alloc_hops = 0;
  logic req_ready, q_full, q_empty, busy, alloc_req, prog_valid;
  logic vc_valid, vc_write, vc_copy, done_valid, rel_valid;
  logic [SLOT_W-1:0] cur_slot, alloc_min_slot, prog_slot, prog_hops, rel_slot, rel_hops;
  logic [BANK_W-1:0] alloc_src, alloc_dst, prog_src, prog_dst, vc_bank, rel_src, rel_dst;
  logic [ID_W-1:0] prog_id, done_id;

  copy_setup_seq #(.SLOT_W(SLOT_W), .ID_W(ID_W), .BANK_W(BANK_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_src(req_src), .req_dst(req_dst), .req_len(req_len),
    .q_full(q_full), .q_empty(q_empty), .busy(busy), .cur_slot(cur_slot),
    .alloc_req(alloc_req), .alloc_src(alloc_src), .alloc_dst(alloc_dst),
    .alloc_min_slot(alloc_min_slot), .alloc_ok(alloc_ok), .alloc_slot(alloc_slot),
    .alloc_hops(alloc_hops), .prog_valid(prog_valid), .prog_src(prog_src),
    .prog_dst(prog_dst), .prog_slot(prog_slot), .prog_hops(prog_hops), .prog_id(prog_id),
    .vc_valid(vc_valid), .vc_write(vc_write), .vc_bank(vc_bank), .vc_copy(vc_copy),
    .done_valid(done_valid), .done_id(done_id), .rel_valid(rel_valid),
    .rel_src(rel_src), .rel_dst(rel_dst), .rel_slot(rel_slot), .rel_hops(rel_hops)
  );

  always #4 clk = ~clk;

  typedef struct {int id; int src; int dst; int len;} rq_t;
  typedef struct {int fails; int off; int hops;} rs_t;
  rq_t pend[$];
  rq_t q[$];
  rs_t resp_q[$];
  rq_t cur;
  int slot_m = 0, active = 0, e = 0, lead = 0, wr_at = 0, rel_at = 0;
  int cur_start = 0, cur_hops = 0;
  int n_cmp = 0, n_bad = 0, cycles = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Reference model: expectations for the current cycle, then next inputs and state.
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_req, exp_prog, exp_rd, exp_wr, exp_rel, ready_m, took;
      rs_t r;
      cycles++;
      if (cycles > 100000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
      end
      exp_req  = !active && q.size() > 0;
      exp_prog = active && e == 1;
      exp_rd   = active && e == lead - 1;
      exp_wr   = active && e == wr_at;
      exp_rel  = active && e == rel_at;
      chk("R2 cur_slot", cur_slot, slot_m);
      chk("R2 alloc_min_slot", alloc_min_slot, (slot_m + 3) % N);
      chk("R3 req_ready", req_ready, q.size() < DEPTH);
      chk("R3 q_full", q_full, q.size() == DEPTH);
      chk("R3 q_empty", q_empty, q.size() == 0);
      chk("R4 busy", busy, active);
      chk("R4 R5 alloc_req", alloc_req, exp_req);
      if (exp_req) begin
        chk("R3 order alloc_src", alloc_src, q[0].src);
        chk("R3 order alloc_dst", alloc_dst, q[0].dst);
      end
      chk("R6 prog_valid", prog_valid, exp_prog);
      if (exp_prog) begin
        chk("R6 prog_src", prog_src, cur.src);
        chk("R6 prog_dst", prog_dst, cur.dst);
        chk("R6 prog_slot", prog_slot, cur_start);
        chk("R6 prog_hops", prog_hops, cur_hops);
        chk("R6 prog_id", prog_id, cur.id);
      end
      chk("R7 R8 vc_valid", vc_valid, exp_rd || exp_wr);
      if (exp_rd) begin
        chk("R7 read vc_write", vc_write, 0);
        chk("R7 read vc_bank", vc_bank, cur.src);
        chk("R9 read vc_copy", vc_copy, 1);
      end
      if (exp_wr) begin
        chk("R8 write vc_write", vc_write, 1);
        chk("R8 write vc_bank", vc_bank, cur.dst);
        chk("R9 write vc_copy", vc_copy, 1);
        chk("R8 done_id", done_id, cur.id);
      end
      chk("R8 done_valid", done_valid, exp_wr);
      chk("R10 rel_valid", rel_valid, exp_rel);
      if (exp_rel) begin
        chk("R10 rel_src", rel_src, cur.src);
        chk("R10 rel_dst", rel_dst, cur.dst);
        chk("R10 rel_slot", rel_slot, cur_start);
        chk("R10 rel_hops", rel_hops, cur_hops);
      end

      // drive inputs for the coming edge
      req_valid = pend.size() > 0;
      if (pend.size() > 0) begin
        req_id = ID_W'(pend[0].id); req_src = BANK_W'(pend[0].src);
        req_dst = BANK_W'(pend[0].dst); req_len = LEN_W'(pend[0].len);
      end
      alloc_ok = 0;
      if (exp_req && resp_q.size() > 0 && resp_q[0].fails == 0) begin
        alloc_ok = 1;
        alloc_slot = SLOT_W'((slot_m + resp_q[0].off) % N);
        alloc_hops = SLOT_W'(resp_q[0].hops);
      end

      // model state after the coming edge
      ready_m = q.size() < DEPTH;
      took = 0;
      if (active) begin
        if (e == rel_at) active = 0; else e++;
      end else if (exp_req) begin
        if (alloc_ok) begin
          int win;
          cur_start = (slot_m + resp_q[0].off) % N;
          cur_hops = resp_q[0].hops;
          lead = (cur_start - slot_m + N) % N;
          if (lead < 3) lead += N;
          win = (q[0].len == 0) ? 1 : q[0].len;
          wr_at = lead + (win - 1) * N + cur_hops;
          rel_at = lead + win * N;
          cur = q.pop_front();
          void'(resp_q.pop_front());
          active = 1; e = 1;
        end else if (resp_q.size() > 0) begin
          r = resp_q[0]; r.fails--; resp_q[0] = r;
        end
      end
      if (req_valid && ready_m) begin
        q.push_back(pend.pop_front());
        took = 1;
      end
      slot_m = (slot_m + 1) % N;
    end
  end

  task automatic add_req(input int id, input int src, input int dst, input int len);
    rq_t t; t.id = id; t.src = src; t.dst = dst; t.len = len; pend.push_back(t);
  endtask

  task automatic add_resp(input int fails, input int off, input int hops);
    rs_t t; t.fails = fails; t.off = off; t.hops = hops; resp_q.push_back(t);
  endtask

  task automatic wait_idle();
    repeat (2) @(posedge clk);
    while (pend.size() > 0 || q.size() > 0 || active) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    chk("R1 cur_slot", cur_slot, 0);
    chk("R1 busy", busy, 0);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 q_empty", q_empty, 1);
    chk("R1 alloc_req", alloc_req, 0);
    chk("R1 pulses", {prog_valid, vc_valid, done_valid, rel_valid}, 0);
    @(posedge clk); #1 rst_n = 1;

    // start three slots ahead, four hops, one beat (R7 R8)
    add_resp(0, 3, 4); add_req(1, 10, 20, 1); wait_idle();
    // start one slot ahead: must wait for the next window (R7)
    add_resp(0, 1, 2); add_req(2, 33, 44, 2); wait_idle();
    // two refusals, then zero length (R5 R10)
    add_resp(2, 5, 3); add_req(3, 7, 9, 0); wait_idle();
    // start slot equal to current slot, largest hop count, three beats (R8)
    add_resp(0, 0, N - 1); add_req(4, 100, 200, 3); wait_idle();
    // burst beyond queue depth, mixed refusals (R3 R4)
    for (int i = 0; i < 6; i++) begin
      add_resp(i % 2, 3 + i, 1 + i);
      add_req(5 + i, 50 + i, 150 + i, (i % 3) + 1);
    end
    wait_idle();
    summary();
  end

endmodule